// File: doc/BRIEF.md
# Strided Vector Unpack Write Engine

This block turns a stream of packed 32-bit input words into 128-bit quadwords and writes them into a local memory. Each quadword holds four 32-bit components. The destination addresses follow a write-cycle pattern set by two configuration values: a write length and a cycle length. When the cycle length is larger than the write length, slots are skipped. This lets several transfers, each with its own compression format, land their records side by side in one array. For example, positions go in one transfer, colours in a second and normals in a third. When the write length is larger, the engine pads every cycle with copies of a programmable fill quadword and consumes no input for those slots.

A configuration command loads the write length, the cycle length and the fill quadword. These values stay in force for every later transfer. A start command supplies the start address, the number of quadwords to write, a format code and a sign flag. The input words arrive on a valid/ready stream. Writes leave through a registered, synchronous memory write port. A one-cycle done pulse marks the end of each transfer.

Top module: `vec_unpack_engine`

## Requirements
- R1: `cfg_valid` loads the write length WL, the cycle length CL and the fill quadword, but only while no transfer is active. A configuration command that arrives while a transfer is busy is ignored. A zero length value is stored as 1. The stored values stay in force until the next configuration command.
- R2: When WL equals CL, write i of a transfer goes to address start+i.
- R3: When CL is greater than WL, write i goes to address start + (i / WL)·CL + (i mod WL). The other addresses keep their contents. With WL=1 and CL=3, transfers starting at 1, 2 and 3 interleave into a strict three-quadword record pattern.
- R4: When WL is greater than CL, write i goes to address start+i. Slot positions (i mod WL) below CL take the next input vector. Slot positions at or above CL write the fill quadword and consume no input.
- R5: A transfer with count N produces exactly N memory writes, fill writes included. The first write goes to the start address. No write happens outside a transfer.
- R6: The format codes are 0 (four 32-bit components, 4 words per vector), 1 (four 16-bit components, 2 words), 2 (four 8-bit components, 1 word) and 3 (one 16-bit colour, two vectors per word). Components are taken from the lowest bits upward. Component 0 lands in quadword bits [31:0] and component 3 in bits [127:96].
- R7: 16-bit and 8-bit components are zero-extended to 32 bits when `cmd_sign` is 0 and sign-extended when it is 1.
- R8: A format 3 half-word expands its bits [4:0], [9:5], [14:10] and [15] into components 0 to 3. Each field is left-aligned in an 8-bit field and zero-extended. The low half of a word is used before the high half.
- R9: `in_ready` is high only while a transfer is active and the engine needs another word. Unused sub-word elements in the last word of a transfer are discarded, so the next transfer starts with a fresh word.
- R10: `done` is high for one cycle, in the cycle after the cycle that carries the last write. A transfer with count 0 writes nothing and still gives a single done pulse.
- R11: Addresses wrap modulo the memory depth, which is a power of two.
- R12: `cmd_ready` is high exactly when no transfer is active. A start command given while busy is ignored.
- R13: After reset, `cmd_ready` is 1 and `in_ready`, `mem_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Load the cycle configuration |
| cfg_wlen | input | CYC_W | Write length (quadwords written per cycle) |
| cfg_clen | input | CYC_W | Cycle length (slots spanned per cycle) |
| cfg_fill | input | 128 | Quadword used for fill slots |
| cmd_valid | input | 1 | Start a transfer |
| cmd_ready | output | 1 | Engine idle, start command accepted |
| cmd_addr | input | AW | Start address |
| cmd_count | input | CNT_W | Quadwords to write |
| cmd_fmt | input | 2 | Packed element format code |
| cmd_sign | input | 1 | Sign-extend 16/8-bit components |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_data | input | 32 | Packed input word |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 128 | Memory write data |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Several properties are checked on every cycle. The input stream must stay closed while the engine is idle, and the configuration must hold still for a whole transfer. Writes may appear only while a transfer runs, and done must follow an idle cycle. Two consecutive writes must step by one address, or, in skipping mode, by one or by the block jump CL−WL+1. Other behaviour needs the bench scenarios. These cover the exact address of every write, the fill and input choice for each slot, the expansion of each format and its sign handling, and the discarding of half-used words. They also cover the wrap at the top of memory, commands given while busy, and the timing of done. The bench rebuilds the whole memory image from the requirements and compares it, including the slots that must stay untouched.

// File: rtl/vup_pkg.sv
package vup_pkg;

  localparam int WORD_W = 32;
  localparam int QW_W   = 128;

  typedef enum logic [1:0] {
    FMT_W32 = 2'd0,
    FMT_H16 = 2'd1,
    FMT_B8  = 2'd2,
    FMT_C5  = 2'd3
  } vup_fmt_e;

  // input words that make up one vector (colour format shares a word)
  function automatic logic [2:0] words_per_vec(input vup_fmt_e f);
    case (f)
      FMT_W32: return 3'd4;
      FMT_H16: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/vup_expand.sv
module vup_expand
  import vup_pkg::*;
(
  input  vup_fmt_e                 fmt,
  input  logic                     sext,
  input  logic [3:0][WORD_W-1:0]   words,
  input  logic                     hi_half,
  output logic [QW_W-1:0]          qword
);

  logic [15:0]           half;
  logic [3:0][7:0]       c5f;
  logic [3:0][WORD_W-1:0] lane;

  assign half = hi_half ? words[0][31:16] : words[0][15:0];
  assign c5f  = {{half[15], 7'b0}, {half[14:10], 3'b0},
                 {half[9:5], 3'b0}, {half[4:0], 3'b0}};

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [15:0]       e16;
    logic [7:0]        e8;
    logic [WORD_W-1:0] x16, x8;
    assign e16 = words[g/2][16*(g%2) +: 16];
    assign e8  = words[0][8*g +: 8];
    assign x16 = sext ? {{16{e16[15]}}, e16} : {16'b0, e16};
    assign x8  = sext ? {{24{e8[7]}}, e8} : {24'b0, e8};
    assign lane[g] = (fmt == FMT_W32) ? words[g] :
                     (fmt == FMT_H16) ? x16 :
                     (fmt == FMT_B8)  ? x8  : {24'b0, c5f[g]};
  end

  assign qword = lane;

endmodule

// File: rtl/vup_gather.sv
module vup_gather
  import vup_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  vup_fmt_e          fmt,
  input  logic              sext,
  input  logic              want,
  input  logic              take,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              word_ready,
  output logic              vec_valid,
  output logic [QW_W-1:0]   vec
);

  logic [3:0][WORD_W-1:0] wbuf_q;
  logic [2:0]             cnt_q, base, need;
  logic                   c5, room, acc;

  // cnt_q counts words held, or halves left for the colour format
  assign need       = words_per_vec(fmt);
  assign c5         = (fmt == FMT_C5);
  assign vec_valid  = c5 ? (cnt_q != 3'd0) : (cnt_q == need);
  assign room       = c5 ? ((cnt_q == 3'd0) || (take && cnt_q == 3'd1))
                         : (!vec_valid || take);
  assign word_ready = want && room;
  assign acc        = word_ready && word_valid;
  assign base       = !take ? cnt_q : (c5 ? cnt_q - 3'd1 : 3'd0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= 3'd0;
    end else if (acc) begin
      cnt_q <= c5 ? 3'd2 : base + 3'd1;
    end else begin
      cnt_q <= base;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      wbuf_q[c5 ? 2'd0 : base[1:0]] <= word;
    end
  end

  vup_expand u_expand (
    .fmt     (fmt),
    .sext    (sext),
    .words   (wbuf_q),
    .hi_half (cnt_q == 3'd1),
    .qword   (vec)
  );

endmodule

// File: rtl/vup_slot_seq.sv
module vup_slot_seq #(
  parameter int AW    = 10,
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    start_addr,
  input  logic             adv,
  input  logic [CYC_W-1:0] wl,
  input  logic [CYC_W-1:0] cl,
  output logic [AW-1:0]    addr,
  output logic             need_in,
  output logic             nxt_need
);

  logic [CYC_W-1:0] pos_q, pos_nxt;
  logic             fill_mode, skip_mode, cyc_end;
  logic [AW-1:0]    step;

  assign fill_mode = wl > cl;
  assign skip_mode = cl > wl;
  assign cyc_end   = (pos_q == wl - CYC_W'(1));
  assign pos_nxt   = cyc_end ? '0 : pos_q + CYC_W'(1);
  assign step      = (skip_mode && cyc_end) ? AW'(cl - wl) + AW'(1) : AW'(1);
  assign need_in   = !(fill_mode && pos_q >= cl);
  assign nxt_need  = !(fill_mode && pos_nxt >= cl);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      addr  <= '0;
    end else if (load) begin
      pos_q <= '0;
      addr  <= start_addr;
    end else if (adv) begin
      pos_q <= pos_nxt;
      addr  <= addr + step;
    end
  end

endmodule

// File: rtl/vec_unpack_engine.sv
module vec_unpack_engine
  import vup_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  parameter int CNT_W     = 16,
  parameter int CYC_W     = 8,
  localparam int AW       = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic [CYC_W-1:0]  cfg_wlen,
  input  logic [CYC_W-1:0]  cfg_clen,
  input  logic [QW_W-1:0]   cfg_fill,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [1:0]        cmd_fmt,
  input  logic              cmd_sign,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [QW_W-1:0]   mem_wdata,
  output logic              done
);

  logic [CYC_W-1:0] wl_q, cl_q;
  logic [QW_W-1:0]  fill_q;
  logic [CNT_W-1:0] rem_q;
  vup_fmt_e         fmt_q;
  logic             sign_q, active_q, fin_q;

  logic             start, adv, take, last, want;
  logic             need_in, nxt_need, vec_valid;
  logic [AW-1:0]    slot_addr;
  logic [QW_W-1:0]  vec;

  assign cmd_ready = !active_q;
  assign start     = cmd_valid && !active_q;
  assign last      = (rem_q == CNT_W'(1));
  assign adv       = active_q && (!need_in || vec_valid);
  assign take      = adv && need_in;
  assign want      = active_q && (take ? (nxt_need && !last) : need_in);

  vup_slot_seq #(.AW(AW), .CYC_W(CYC_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .load       (start),
    .start_addr (cmd_addr),
    .adv        (adv),
    .wl         (wl_q),
    .cl         (cl_q),
    .addr       (slot_addr),
    .need_in    (need_in),
    .nxt_need   (nxt_need)
  );

  vup_gather u_gather (
    .clk        (clk),
    .rst        (rst),
    .clear      (start),
    .fmt        (fmt_q),
    .sext       (sign_q),
    .want       (want),
    .take       (take),
    .word_valid (in_valid),
    .word       (in_data),
    .word_ready (in_ready),
    .vec_valid  (vec_valid),
    .vec        (vec)
  );

  // configuration: frozen while a transfer runs
  always_ff @(posedge clk) begin
    if (rst) begin
      wl_q   <= CYC_W'(1);
      cl_q   <= CYC_W'(1);
      fill_q <= '0;
    end else if (cfg_valid && !active_q) begin
      wl_q   <= (cfg_wlen == '0) ? CYC_W'(1) : cfg_wlen;
      cl_q   <= (cfg_clen == '0) ? CYC_W'(1) : cfg_clen;
      fill_q <= cfg_fill;
    end
  end

  // transfer control and registered write port
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      rem_q     <= '0;
      fmt_q     <= FMT_W32;
      sign_q    <= 1'b0;
      fin_q     <= 1'b0;
      done      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      fin_q  <= 1'b0;
      mem_we <= 1'b0;
      done   <= fin_q;
      if (start) begin
        active_q <= (cmd_count != '0);
        rem_q    <= cmd_count;
        fmt_q    <= vup_fmt_e'(cmd_fmt);
        sign_q   <= cmd_sign;
        fin_q    <= (cmd_count == '0);
      end else if (adv) begin
        mem_we    <= 1'b1;
        mem_addr  <= slot_addr;
        mem_wdata <= need_in ? vec : fill_q;
        rem_q     <= rem_q - CNT_W'(1);
        if (last) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vup_chk.sv
module vup_chk #(
  parameter int AW    = 10,
  parameter int CYC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_ready,
  input logic             in_ready,
  input logic             mem_we,
  input logic             done,
  input logic [AW-1:0]    mem_addr,
  input logic [CYC_W-1:0] wl,
  input logic [CYC_W-1:0] cl
);

  logic          prev_we;
  logic [AW-1:0] prev_addr, delta, jump;

  always_ff @(posedge clk) begin
    if (rst) prev_we <= 1'b0;
    else     prev_we <= mem_we;
    prev_addr <= mem_addr;
  end

  assign delta = mem_addr - prev_addr;
  assign jump  = AW'(cl - wl) + AW'(1);

  // R9
  idle_no_input_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !in_ready);

  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ready && $past(!cmd_ready)) |-> ($stable(wl) && $stable(cl)));

  // R5
  write_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(!cmd_ready));

  // R2 R4
  dense_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && prev_we && wl >= cl) |-> (delta == AW'(1)));

  // R3
  skip_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && prev_we && cl > wl) |-> (delta == AW'(1) || delta == jump));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cmd_ready));

endmodule

bind vec_unpack_engine vup_chk #(.AW(AW), .CYC_W(CYC_W)) u_vup_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .in_ready  (in_ready),
  .mem_we    (mem_we),
  .done      (done),
  .mem_addr  (mem_addr),
  .wl        (wl_q),
  .cl        (cl_q)
);

// File: tb/test_vec_unpack_engine.sv
`timescale 1ns/1ps
module test_vec_unpack_engine;

  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic         clk = 0;
  logic         rst = 1;
  logic         cfg_valid = 0;
  logic [7:0]   cfg_wlen = 0, cfg_clen = 0;
  logic [127:0] cfg_fill = 0;
  logic         cmd_valid = 0;
  logic         cmd_ready;
  logic [AW-1:0] cmd_addr = 0;
  logic [15:0]  cmd_count = 0;
  logic [1:0]   cmd_fmt = 0;
  logic         cmd_sign = 0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [31:0]  in_data = 0;
  logic         mem_we;
  logic [AW-1:0] mem_addr;
  logic [127:0] mem_wdata;
  logic         done;

  always #10 clk = ~clk;

  vec_unpack_engine i_vec_unpack_engine (
    .clk(clk), .rst(rst),
    .cfg_valid(cfg_valid), .cfg_wlen(cfg_wlen), .cfg_clen(cfg_clen), .cfg_fill(cfg_fill),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cmd_fmt(cmd_fmt), .cmd_sign(cmd_sign),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );

  logic [31:0]  src    [0:255];
  logic [127:0] tbmem  [0:DEPTH-1];
  logic [127:0] expmem [0:DEPTH-1];
  int checks = 0, fails = 0;
  int cyc = 0, we_cnt = 0, done_cnt = 0, last_we = 0, done_at = 0;
  int cur_wl = 1, cur_cl = 1;
  logic [127:0] cur_fill = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && mem_we) begin
      we_cnt++;
      last_we = cyc;
      tbmem[mem_addr] = mem_wdata;
    end
    if (!rst && done) begin
      done_cnt++;
      done_at = cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] x16(input logic [15:0] v, input bit s);
    return s ? {{16{v[15]}}, v} : {16'b0, v};
  endfunction

  function automatic logic [31:0] x8(input logic [7:0] v, input bit s);
    return s ? {{24{v[7]}}, v} : {24'b0, v};
  endfunction

  function automatic logic [127:0] model_vec(input int f, input bit s, input int k);
    logic [31:0] w0, w1;
    logic [15:0] h;
    case (f)
      0: return {src[4*k+3], src[4*k+2], src[4*k+1], src[4*k]};
      1: begin
        w0 = src[2*k]; w1 = src[2*k+1];
        return {x16(w1[31:16], s), x16(w1[15:0], s), x16(w0[31:16], s), x16(w0[15:0], s)};
      end
      2: begin
        w0 = src[k];
        return {x8(w0[31:24], s), x8(w0[23:16], s), x8(w0[15:8], s), x8(w0[7:0], s)};
      end
      default: begin
        w0 = src[k/2];
        h = (k % 2 == 1) ? w0[31:16] : w0[15:0];
        return {24'b0, h[15], 7'b0, 24'b0, h[14:10], 3'b0,
                24'b0, h[9:5], 3'b0, 24'b0, h[4:0], 3'b0};
      end
    endcase
  endfunction

  task automatic set_cfg(input int w, input int c, input logic [127:0] f);
    @(negedge clk);
    cfg_valid = 1; cfg_wlen = 8'(w); cfg_clen = 8'(c); cfg_fill = f;
    @(negedge clk);
    cfg_valid = 0;
    cur_wl = (w == 0) ? 1 : w;
    cur_cl = (c == 0) ? 1 : c;
    cur_fill = f;
  endtask

  task automatic feed(input int nw);
    int idx = 0;
    while (idx < nw) begin
      @(negedge clk);
      in_valid = (($urandom % 4) != 0);
      in_data  = src[idx];
      #1;
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run_xfer(input int start, input int count, input int f, input bit s,
                          input string tag, input bit poke);
    int k = 0;
    int nw;
    for (int i = 0; i < 256; i++) src[i] = $urandom;
    for (int i = 0; i < count; i++) begin
      int p = i % cur_wl;
      int cy = i / cur_wl;
      int a;
      bit inp = 1;
      if (cur_wl > cur_cl) begin a = start + i; inp = (p < cur_cl); end
      else if (cur_cl > cur_wl) a = start + cy * cur_cl + p;
      else a = start + i;
      a = a % DEPTH;
      expmem[a] = inp ? model_vec(f, s, k) : cur_fill;
      if (inp) k++;
    end
    nw = (f == 0) ? 4*k : (f == 1) ? 2*k : (f == 2) ? k : (k + 1) / 2;
    @(negedge clk);
    we_cnt = 0; done_cnt = 0;
    cmd_valid = 1; cmd_addr = AW'(start); cmd_count = 16'(count);
    cmd_fmt = 2'(f); cmd_sign = s;
    #1 chk(cmd_ready == 1, "R12 idle ready", 128'(cmd_ready), 128'(1));
    @(negedge clk);
    cmd_valid = 0;
    fork
      feed(nw);
      begin
        while (done_cnt == 0) @(negedge clk);
      end
      if (poke) begin
        repeat (3) @(negedge clk);
        cfg_valid = 1; cfg_wlen = 8'd5; cfg_clen = 8'd2; cfg_fill = '1;
        cmd_valid = 1; cmd_addr = '0; cmd_count = 16'd3;
        #1 chk(cmd_ready == 0, "R12 busy", 128'(cmd_ready), 128'(0));
        @(negedge clk);
        cfg_valid = 0; cmd_valid = 0;
      end
    join
    repeat (3) @(negedge clk);
    chk(we_cnt == count, "R5 write count", 128'(we_cnt), 128'(count));
    chk(done_cnt == 1, "R10 done pulses", 128'(done_cnt), 128'(1));
    if (count > 0) chk(done_at == last_we + 1, "R10 done timing", 128'(done_at), 128'(last_we + 1));
    chk(in_ready == 0, "R9 idle in_ready", 128'(in_ready), 128'(0));
    for (int a = 0; a < DEPTH; a++)
      chk(tbmem[a] === expmem[a], tag, tbmem[a], expmem[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < DEPTH; a++) begin
      tbmem[a]  = {4{32'h5A000000 | 32'(a)}};
      expmem[a] = tbmem[a];
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    // R13 reset state
    chk(cmd_ready == 1, "R13 cmd_ready", 128'(cmd_ready), 128'(1));
    chk(in_ready == 0, "R13 in_ready", 128'(in_ready), 128'(0));
    chk(mem_we == 0, "R13 mem_we", 128'(mem_we), 128'(0));
    chk(done == 0, "R13 done", 128'(done), 128'(0));

    // R9: input offered while idle is not taken
    in_valid = 1; in_data = 32'hDEADBEEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1 chk(in_ready == 0, "R9 idle offer", 128'(in_ready), 128'(0));
    end
    in_valid = 0;

    // R3 interleave of three differently packed streams
    set_cfg(1, 3, '0);
    run_xfer(1, 4, 1, 0, "R3 interleave xyz", 0);
    run_xfer(2, 4, 2, 0, "R3 interleave rgba", 0);
    run_xfer(3, 4, 1, 0, "R3 interleave normal", 0);

    // R4 filling
    set_cfg(3, 2, {4{32'hF111F111}});
    run_xfer(100, 10, 0, 0, "R4 fill", 0);
    run_xfer(130, 7, 3, 0, "R4 fill colour", 0);

    // R2 equal lengths, R1 zero lengths become one
    set_cfg(2, 2, '0);
    run_xfer(200, 6, 2, 0, "R2 dense", 0);
    set_cfg(0, 0, '0);
    run_xfer(220, 5, 0, 0, "R1 zero lengths", 0);

    // R6 formats, R7 sign extension
    run_xfer(240, 6, 0, 0, "R6 w32", 0);
    run_xfer(260, 6, 2, 0, "R6 b8", 0);
    run_xfer(300, 8, 1, 1, "R7 sign h16", 0);
    run_xfer(320, 8, 2, 1, "R7 sign b8", 0);

    // R8 colour with odd count, then R9 fresh word for the next transfer
    run_xfer(340, 3, 3, 0, "R8 colour odd", 0);
    run_xfer(350, 4, 2, 0, "R9 fresh word", 0);

    // R11 wrap
    set_cfg(1, 2, '0);
    run_xfer(1022, 5, 0, 0, "R11 wrap", 0);

    // R10 zero count
    run_xfer(400, 0, 0, 0, "R10 zero count", 0);

    // R12 and R1: commands while busy are ignored
    run_xfer(500, 12, 0, 0, "R12 busy ignore", 1);
    run_xfer(560, 4, 2, 0, "R1 cfg kept", 0);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int w = 1 + ($urandom % 4);
      int c = 1 + ($urandom % 4);
      string tg;
      set_cfg(w, c, {$urandom, $urandom, $urandom, $urandom});
      tg = (w == c) ? "R2 random" : (c > w) ? "R3 random" : "R4 random";
      run_xfer($urandom % DEPTH, $urandom % 21, $urandom % 4, 1'($urandom % 2), tg, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule